// File: doc/BRIEF.md
# Multi-Mode Ratio Clock Divider

This block lowers the rate of a source tick stream by a programmable ratio and presents the result as a one-cycle enable pulse plus a square-wave level. It works entirely inside the `clk` domain. Each candidate source arrives as a tick enable on `src_tick`, and a small source selector in front of the divider picks one of them. A single control word, loaded through `cfg_we`/`cfg_wdata`, holds two fields: a source index and a ratio field. How the ratio field is read is fixed at elaboration by the `MODE` parameter:

- `DM_PLUS1`: field + 1
- `DM_DOUBLE`: twice (field + 1)
- `DM_SHIFT`: two to the power of the field
- `DM_CONST`: a constant `CONST_RATIO`, and the field is ignored

Field positions and widths are parameters. In the default layout the source index sits in `cfg_wdata[2:0]` and the ratio field in `cfg_wdata[7:3]`. A newly written ratio is held back until the period in progress has finished, so an output period is never cut short.

Top module: `ratio_clk_divider`

## Requirements
- R1: While `rst` is high and after it is released, `div_en` and `div_clk` are 0. The first period uses the ratio decoded from the reset field values `RST_SEL`/`RST_FLD`. With the defaults this is source 0 and ratio 4.
- R2: In `DM_PLUS1` mode, `div_en` pulses once for every field+1 ticks of the selected source.
- R3: In `DM_DOUBLE` mode, `div_en` pulses once for every 2*(field+1) selected ticks.
- R4: In `DM_SHIFT` mode, the ratio is 2^field. A field of 0 gives a pulse on every selected tick.
- R5: In `DM_CONST` mode, the ratio is always `CONST_RATIO`, and writes to the ratio field change nothing at the output.
- R6: The source index (default `cfg_wdata[2:0]`) chooses which `src_tick` bit is counted. An index equal to or greater than `NUM_SRC` counts `src_tick[0]`.
- R7: A write with `cfg_we` high captures both fields at that clock edge. The new source is used from the next edge. The new ratio applies from the period after the one in progress, and that period still completes with the old ratio.
- R8: `div_en` is high for exactly one cycle. It rises in the cycle right after the clock edge that sampled the tick completing a period.
- R9: With an even ratio, `div_clk` is high for the second half of the ratio/2 ticks... specifically, it is high from the tick ending the first half of the period until the tick ending the period. With an odd ratio, including 1, `div_clk` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | NUM_SRC | One tick enable per candidate source |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | CTRL_W | Control word: source index and ratio field |
| div_en | output | 1 | One-cycle pulse at the end of each output period |
| div_clk | output | 1 | Half-period level for even ratios, 0 for odd |

## Verification
A wrong counter or latched ratio appears as an output period whose length, counted in selected-source ticks, differs from the expected one. This is visible at the very next `div_en` pulse, so the error shows within one period. A selector fault changes which source ticks are counted, and the first period after the faulty index is written will be too long, too short or missing. A fault in the hold-until-period-end rule shows up only in the single period that straddles a write, so every write is checked for that one old-ratio period. A duty fault shows up as the wrong count of high cycles within a single period.

// File: rtl/rcd_pkg.sv
`timescale 1ns/1ps
package rcd_pkg;

  typedef enum logic [1:0] {
    DM_CONST  = 2'd0,
    DM_PLUS1  = 2'd1,
    DM_DOUBLE = 2'd2,
    DM_SHIFT  = 2'd3
  } div_mode_e;

  // Bits needed to hold the largest ratio a mode can encode.
  function automatic int ratio_width(div_mode_e m, int fw, int cr);
    case (m)
      DM_CONST:  return (cr < 2) ? 1 : $clog2(cr + 1);
      DM_PLUS1:  return fw + 1;
      DM_DOUBLE: return fw + 2;
      default:   return (1 << fw);
    endcase
  endfunction

  // Elaboration-time ratio for a given field value (reset value only).
  function automatic longint ratio_value(div_mode_e m, int fv, int cr);
    case (m)
      DM_CONST:  return longint'(cr);
      DM_PLUS1:  return longint'(fv) + 1;
      DM_DOUBLE: return 2 * (longint'(fv) + 1);
      default:   return longint'(1) << fv;
    endcase
  endfunction

endpackage

// File: rtl/rcd_src_select.sv
`timescale 1ns/1ps
module rcd_src_select #(
  parameter int NUM_SRC = 5,
  parameter int SEL_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic [SEL_W-1:0]   sel,
  output logic               tick_out
);

  localparam int SEL_SPAN = 1 << SEL_W;

  logic               in_range;
  logic [NUM_SRC-1:0] hit;

  assign in_range = (32'(sel) < NUM_SRC);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_leg
      if (gi == 0) begin : g_zero
        // Input 0 also catches every out-of-range index.
        assign hit[gi] = src_tick[gi] & (~in_range | (sel == '0));
      end else if (gi < SEL_SPAN) begin : g_reach
        assign hit[gi] = src_tick[gi] & in_range & (sel == SEL_W'(gi));
      end else begin : g_unreach
        assign hit[gi] = 1'b0;
      end
    end
  endgenerate

  assign tick_out = |hit;

  AST_SEL_FALLBACK: assert property (@(posedge clk) disable iff (rst)
    (32'(sel) >= NUM_SRC) |-> (tick_out == src_tick[0])) else $error("fallback"); // R6

  AST_SEL_SINGLE_LEG: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit)) else $error("more than one leg"); // R6

endmodule

// File: rtl/rcd_ratio_decode.sv
`timescale 1ns/1ps
module rcd_ratio_decode
  import rcd_pkg::*;
#(
  parameter div_mode_e MODE        = DM_PLUS1,
  parameter int        FLD_W       = 5,
  parameter int        CONST_RATIO = 2,
  parameter int        RATIO_W     = 6
) (
  input  logic [FLD_W-1:0]   fld,
  output logic [RATIO_W-1:0] ratio
);

  generate
    case (MODE)
      DM_CONST: begin : g_const
        assign ratio = RATIO_W'(CONST_RATIO);
      end
      DM_PLUS1: begin : g_plus1
        assign ratio = RATIO_W'(fld) + RATIO_W'(1);
      end
      DM_DOUBLE: begin : g_double
        assign ratio = (RATIO_W'(fld) + RATIO_W'(1)) << 1;
      end
      default: begin : g_shift
        assign ratio = RATIO_W'(1) << fld;
      end
    endcase
  endgenerate

endmodule

// File: rtl/rcd_counter.sv
`timescale 1ns/1ps
module rcd_counter #(
  parameter int                  RATIO_W   = 6,
  parameter logic [RATIO_W-1:0]  RST_RATIO = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [RATIO_W-1:0] ratio_next,
  output logic               en_out,
  output logic               clk_out
);

  logic [RATIO_W-1:0] cnt_q;
  logic [RATIO_W-1:0] ratio_q;
  logic               en_q;
  logic               lvl_q;
  logic               last;
  logic               mid;

  assign last = (cnt_q == ratio_q - RATIO_W'(1));
  assign mid  = ~ratio_q[0] && (cnt_q == (ratio_q >> 1) - RATIO_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      ratio_q <= RST_RATIO;
      en_q    <= 1'b0;
      lvl_q   <= 1'b0;
    end else begin
      en_q <= tick && last;
      if (tick) begin
        if (last) begin
          cnt_q   <= '0;
          ratio_q <= ratio_next;
          lvl_q   <= 1'b0;
        end else begin
          cnt_q <= cnt_q + RATIO_W'(1);
          if (mid) lvl_q <= 1'b1;
        end
      end
    end
  end

  assign en_out  = en_q;
  assign clk_out = lvl_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q < ratio_q) else $error("count past ratio"); // R2

  AST_RATIO_NONZERO: assert property (@(posedge clk) disable iff (rst)
    ratio_q != '0) else $error("zero ratio"); // R4

  AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(tick && last) |=> $stable(ratio_q)) else $error("ratio moved mid-period"); // R7

  AST_PULSE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    en_q |-> $past(tick)) else $error("pulse without tick"); // R8

  AST_ODD_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
    ratio_q[0] |-> !lvl_q) else $error("odd ratio drove level"); // R9

endmodule

// File: rtl/ratio_clk_divider.sv
`timescale 1ns/1ps
module ratio_clk_divider
  import rcd_pkg::*;
#(
  parameter div_mode_e MODE        = DM_PLUS1,
  parameter int        NUM_SRC     = 5,
  parameter int        CTRL_W      = 8,
  parameter int        SEL_LSB     = 0,
  parameter int        SEL_W       = 3,
  parameter int        FLD_LSB     = 3,
  parameter int        FLD_W       = 5,
  parameter int        CONST_RATIO = 2,
  parameter int        RST_SEL     = 0,
  parameter int        RST_FLD     = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic               cfg_we,
  input  logic [CTRL_W-1:0]  cfg_wdata,
  output logic               div_en,
  output logic               div_clk
);

  localparam int                 RATIO_W   = ratio_width(MODE, FLD_W, CONST_RATIO);
  localparam logic [RATIO_W-1:0] RST_RATIO =
    RATIO_W'(ratio_value(MODE, RST_FLD, CONST_RATIO));

  logic [SEL_W-1:0]   sel_q;
  logic [FLD_W-1:0]   fld_q;
  logic               sel_tick;
  logic [RATIO_W-1:0] ratio_dec;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= SEL_W'(RST_SEL);
      fld_q <= FLD_W'(RST_FLD);
    end else if (cfg_we) begin
      sel_q <= cfg_wdata[SEL_LSB +: SEL_W];
      fld_q <= cfg_wdata[FLD_LSB +: FLD_W];
    end
  end

  rcd_src_select #(
    .NUM_SRC (NUM_SRC),
    .SEL_W   (SEL_W)
  ) u_sel (
    .clk      (clk),
    .rst      (rst),
    .src_tick (src_tick),
    .sel      (sel_q),
    .tick_out (sel_tick)
  );

  rcd_ratio_decode #(
    .MODE        (MODE),
    .FLD_W       (FLD_W),
    .CONST_RATIO (CONST_RATIO),
    .RATIO_W     (RATIO_W)
  ) u_dec (
    .fld   (fld_q),
    .ratio (ratio_dec)
  );

  rcd_counter #(
    .RATIO_W   (RATIO_W),
    .RST_RATIO (RST_RATIO)
  ) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick       (sel_tick),
    .ratio_next (ratio_dec),
    .en_out     (div_en),
    .clk_out    (div_clk)
  );

endmodule

// File: tb/tb_ratio_clk_divider.sv
`timescale 1ns/1ps
module tb_ratio_clk_divider;
  import rcd_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] src_tick = '0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       div_en, div_clk;

  logic [2:0] side_we = '0;
  logic [7:0] side_wdata = '0;
  logic [2:0] side_en, side_clk;

  int checks = 0;
  int fails = 0;

  int exp_q[$];
  string tag_q[$];
  int exp_now;

  int side_pulses[3];
  int side_p[3];
  int side_h[3];
  int last_p[3];
  int last_h[3];

  always #4 clk = ~clk;

  ratio_clk_divider dut (
    .clk(clk), .rst(rst), .src_tick(src_tick), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .div_en(div_en), .div_clk(div_clk));

  ratio_clk_divider #(.MODE(DM_DOUBLE), .NUM_SRC(1), .SEL_W(1), .FLD_W(2))
  dut_dbl (.clk(clk), .rst(rst), .src_tick(src_tick[0:0]), .cfg_we(side_we[0]),
    .cfg_wdata(side_wdata), .div_en(side_en[0]), .div_clk(side_clk[0]));

  ratio_clk_divider #(.MODE(DM_SHIFT), .NUM_SRC(1), .SEL_W(1), .FLD_W(3))
  dut_shf (.clk(clk), .rst(rst), .src_tick(src_tick[0:0]), .cfg_we(side_we[1]),
    .cfg_wdata(side_wdata), .div_en(side_en[1]), .div_clk(side_clk[1]));

  ratio_clk_divider #(.MODE(DM_CONST), .NUM_SRC(1), .SEL_W(1), .FLD_W(5), .CONST_RATIO(3))
  dut_cst (.clk(clk), .rst(rst), .src_tick(src_tick[0:0]), .cfg_we(side_we[2]),
    .cfg_wdata(side_wdata), .div_en(side_en[2]), .div_clk(side_clk[2]));

  function automatic int eff_sel(logic [2:0] s);
    return (int'(s) >= 5) ? 0 : int'(s);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Source k ticks on every (k+1)-th cycle.
  initial begin
    int cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      for (int k = 0; k < 5; k++) src_tick[k] = ((cyc % (k + 1)) == 0);
    end
  end

  // Scoreboard monitor for the main instance: selected ticks per period.
  initial begin
    int ticks_since = 0;
    int mon_sel = 0;
    int e;
    string t;
    forever begin
      @(posedge clk); #2;
      if (rst) begin
        ticks_since = 0;
        mon_sel = 0;
      end else begin
        if (src_tick[mon_sel]) ticks_since++;
        if (div_en) begin
          if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(ticks_since == e, t, ticks_since, e);
          end
          ticks_since = 0;
        end
        if (cfg_we) mon_sel = eff_sel(cfg_wdata[2:0]);
      end
    end
  end

  // Period and high-time monitor for the single-source instances.
  initial begin
    forever begin
      @(posedge clk); #2;
      for (int k = 0; k < 3; k++) begin
        if (rst) begin
          side_p[k] = 0; side_h[k] = 0; side_pulses[k] = 0;
        end else begin
          side_p[k]++;
          if (side_clk[k]) side_h[k]++;
          if (side_en[k]) begin
            last_p[k] = side_p[k];
            last_h[k] = side_h[k];
            side_p[k] = 0;
            side_h[k] = 0;
            side_pulses[k]++;
          end
        end
      end
    end
  end

  task automatic main_cfg(input int sel, input int fld, input int n, input string tag);
    do @(negedge clk); while (exp_q.size() != 0);
    do @(negedge clk); while (!div_en);
    cfg_wdata = 8'((fld << 3) | sel);
    cfg_we = 1'b1;
    exp_q.push_back(exp_now); tag_q.push_back("R7");
    exp_now = fld + 1;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(exp_now); tag_q.push_back(tag);
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic side_check(input int k, input bit wr, input int fld,
                            input int exp_p, input int exp_h, input string tag);
    int base;
    if (wr) begin
      @(negedge clk);
      side_wdata = 8'(fld << 3);
      side_we[k] = 1'b1;
      @(negedge clk);
      side_we[k] = 1'b0;
    end
    base = side_pulses[k];
    do @(negedge clk); while (side_pulses[k] < base + 3);
    chk(last_p[k] == exp_p, tag, last_p[k], exp_p);
    chk(last_h[k] == exp_h, {tag, " R9"}, last_h[k], exp_h);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    exp_now = 4;
    for (int i = 0; i < 3; i++) begin
      exp_q.push_back(4); tag_q.push_back("R1");
    end
    repeat (4) @(negedge clk);
    chk(div_en == 1'b0, "R1 en in reset", int'(div_en), 0);
    chk(div_clk == 1'b0, "R1 clk in reset", int'(div_clk), 0);
    chk(side_en == 3'b000, "R1 side en in reset", int'(side_en), 0);
    rst = 1'b0;
    @(posedge clk); #2;
    chk(div_en == 1'b0, "R1 en after reset", int'(div_en), 0);

    main_cfg(1, 2, 3, "R2 R6 src1");
    main_cfg(2, 4, 2, "R2 R6 src2");
    main_cfg(6, 1, 3, "R6 fallback idx6");
    main_cfg(4, 31, 2, "R2 R6 src4 max");
    main_cfg(7, 0, 4, "R2 R6 R8 ratio1 idx7");
    do @(negedge clk); while (exp_q.size() != 0);

    side_check(0, 1'b0, 0, 8, 4, "R1 R3 R8 dbl reset ratio");
    side_check(0, 1'b1, 0, 2, 1, "R3 R8 dbl fld0");
    side_check(0, 1'b1, 2, 6, 3, "R3 R8 dbl fld2");
    side_check(1, 1'b0, 0, 8, 4, "R1 R4 shf reset ratio");
    side_check(1, 1'b1, 5, 32, 16, "R4 shf fld5");
    side_check(1, 1'b1, 0, 1, 0, "R4 shf fld0");
    side_check(2, 1'b0, 0, 3, 0, "R5 cst");
    side_check(2, 1'b1, 7, 3, 0, "R5 cst write ignored");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule